// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers interrupt requests from a set of devices and drives a single request line towards a processor. Request lines are examined only on cycles where the processor marks an instruction boundary. A low-to-high change seen on such a cycle records that source as pending. The pending source with the lowest index wins. The processor answers the request line with an acknowledge pulse. In that same cycle the block puts the winner's index on the identifier output, moves the source from pending to in service, and removes it from the pending set.

When a service routine finishes, the processor pulses the end-of-service strobe. This retires the highest-priority service still open, so nested services unwind in the correct order. Pending requests are then handed over one at a time by priority, whether they are old or new, until none remain. A mode input selects between two behaviours. In run-to-completion mode, nothing is offered while any service is open. In nested mode, a new request is offered only if it outranks every open service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, irq_o is 0, src_id_o is 0 and in_svc_o is all zeros.
- R2: A source becomes pending only on a cycle with smp_en_i high where its request is 1 and was 0 at the previous sampling cycle. Changes on cycles with smp_en_i low are not seen, and a held-high request does not pend again.
- R3: When several sources are pending, the lowest index is the candidate, and src_id_o shows it as a binary index while irq_o is high.
- R4: An acknowledge in a cycle with irq_o high sets the candidate's in_svc_o bit and clears its pending bit from the next cycle. An acknowledge while irq_o is low changes nothing.
- R5: An end-of-service pulse clears the lowest-index set bit of in_svc_o on the next cycle. With no service open, it has no effect.
- R6: With nest_mode_i at 0 (run to completion), irq_o is low whenever any in_svc_o bit is set.
- R7: With nest_mode_i at 1 (nested), irq_o is high during an open service only if the candidate index is strictly lower than the lowest set in_svc_o index.
- R8: irq_o stays high while an eligible source is pending, so pending sources, including ones that arrive later, are served one by one in index order until none are left.
- R9: src_id_o is 0 whenever irq_o is low.
- R10: A new rising edge on a source in the same cycle that the source is acknowledged leaves it pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_SRC | Request level per source, index 0 highest |
| smp_en_i | input | 1 | Instruction-boundary sample enable |
| ack_i | input | 1 | Interrupt acknowledge from processor |
| eos_i | input | 1 | End-of-service strobe |
| nest_mode_i | input | 1 | 0 run to completion, 1 nested |
| irq_o | output | 1 | Interrupt request to processor |
| src_id_o | output | ID_W | Index of the source being offered |
| in_svc_o | output | N_SRC | Sources currently in service |

## Verification
The assertions assume that all inputs carry known values from reset onward. They also assume that acknowledge and end-of-service are single-cycle pulses, each naming one event. The end-of-service count property is conditioned on no acknowledge in the same cycle, because an accept and a retire together leave the count unchanged. The stimulus changes every input only at the falling clock edge, with known values. Directed phases walk through drain order, preemption limits and ignored pulses. A pseudo-random phase mixes the inputs freely against the bench's own model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    MODE_RUN_TO_END = 1'b0,
    MODE_NESTED     = 1'b1
  } svc_mode_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             smp_en_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] prev_q, prev_d;
  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] rise;

  // edge detection relative to the last sampled level
  always_comb begin
    rise   = smp_en_i ? (req_i & ~prev_q) : '0;
    prev_d = smp_en_i ? req_i : prev_q;
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      if (smp_en_i) prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R2 R10
  rise_pends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R2
  no_sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_en_i && clr_i == '0) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 8,
  parameter int ID_W  = 3
) (
  input  logic [N_SRC-1:0] vec_i,
  output logic             hit_o,
  output logic [ID_W-1:0]  idx_o,
  output logic [N_SRC-1:0] sel_o
);
  // lowest set index wins; scan from the top so the last match is lowest
  always_comb begin
    idx_o = '0;
    sel_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = ID_W'(i);
        sel_o = '0;
        sel_o[i] = 1'b1;
      end
    end
    hit_o = |vec_i;
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             eos_i,
  input  logic [N_SRC-1:0] top_sel_i,
  output logic [N_SRC-1:0] isr_o
);
  logic [N_SRC-1:0] isr_q, isr_d;
  logic [N_SRC-1:0] retire;

  always_comb begin
    retire = eos_i ? top_sel_i : '0;
    isr_d  = (isr_q & ~retire) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  // R5
  eos_retires_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && isr_q != '0 && set_i == '0) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R5
  eos_empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q == '0 && set_i == '0) |=> (isr_q == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic             smp_en_i,
  input  logic             ack_i,
  input  logic             eos_i,
  input  logic             nest_mode_i,
  output logic             irq_o,
  output logic [ID_W-1:0]  src_id_o,
  output logic [N_SRC-1:0] in_svc_o
);
  logic [N_SRC-1:0] pend, isr;
  logic [N_SRC-1:0] pend_sel, isr_sel;
  logic [ID_W-1:0]  pend_idx, isr_idx;
  logic             pend_hit, isr_hit;
  logic             offer, take;
  logic [N_SRC-1:0] take_mask;
  svc_mode_e        mode;

  irq_edge_latch #(.N_SRC(N_SRC)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (irq_req_i),
    .smp_en_i (smp_en_i),
    .clr_i    (take_mask),
    .pend_o   (pend)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick_pend (
    .vec_i (pend),
    .hit_o (pend_hit),
    .idx_o (pend_idx),
    .sel_o (pend_sel)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick_isr (
    .vec_i (isr),
    .hit_o (isr_hit),
    .idx_o (isr_idx),
    .sel_o (isr_sel)
  );

  irq_svc_track #(.N_SRC(N_SRC)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (take_mask),
    .eos_i     (eos_i),
    .top_sel_i (isr_sel),
    .isr_o     (isr)
  );

  // eligibility: idle, or nested mode with a strictly more urgent candidate
  always_comb begin
    mode = svc_mode_e'(nest_mode_i);
    offer = 1'b0;
    if (pend_hit) begin
      if (!isr_hit)                                       offer = 1'b1;
      else if (mode == MODE_NESTED && pend_idx < isr_idx) offer = 1'b1;
    end
    take      = ack_i & offer;
    take_mask = take ? pend_sel : '0;
  end

  assign irq_o    = offer;
  assign src_id_o = offer ? pend_idx : '0;
  assign in_svc_o = isr;

  // R8
  irq_has_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0));

  // R4
  ack_enters_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> in_svc_o[$past(src_id_o)]);

  // R4
  ack_idle_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !eos_i) |=> $stable(in_svc_o));

  // R6
  run_to_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nest_mode_i && in_svc_o != '0) |-> !irq_o);

  // R7
  nest_outranks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && isr_hit) |-> (src_id_o < isr_idx));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          se, ak, eo, md;
  logic          irq;
  logic [IW-1:0] sid;
  logic [N-1:0]  isv;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [N-1:0] m_prev, m_pend, m_isr;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .smp_en_i(se),
    .ack_i(ak), .eos_i(eo), .nest_mode_i(md),
    .irq_o(irq), .src_id_o(sid), .in_svc_o(isv)
  );

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic e_irq,
                       input logic [IW-1:0] e_id, input logic [N-1:0] e_isv);
    n_chk++;
    if (irq !== e_irq || sid !== e_id || isv !== e_isv) begin
      n_fail++;
      $display("FAIL %s: irq=%b id=%0d isv=%b expected irq=%b id=%0d isv=%b",
               tag, irq, sid, isv, e_irq, e_id, e_isv);
    end
  endtask

  // one clock: drive at falling edge, compare, advance the model
  task automatic step(input logic [N-1:0] rq, input logic s, input logic a,
                      input logic e, input logic m, input string tag);
    int c, t;
    logic e_irq;
    logic [IW-1:0] e_id;
    logic [N-1:0] rise;
    @(negedge clk);
    req = rq; se = s; ak = a; eo = e; md = m;
    #1;
    c = lowest(m_pend);
    t = lowest(m_isr);
    e_irq = (c >= 0) && ((t < 0) || (m && c < t));
    e_id  = e_irq ? IW'(c) : '0;
    check(tag, e_irq, e_id, m_isr);
    rise = s ? (rq & ~m_prev) : '0;
    if (s) m_prev = rq;
    if (e && t >= 0) m_isr[t] = 1'b0;
    if (a && e_irq) begin
      m_pend[c] = 1'b0;
      m_isr[c]  = 1'b1;
    end
    m_pend = m_pend | rise;
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [N-1:0] r;
    rst_n = 1'b0; req = '0; se = 0; ak = 0; eo = 0; md = 0;
    m_prev = '0; m_pend = '0; m_isr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 1'b0, '0, '0);
    rst_n = 1'b1;
    step('0, 1, 0, 0, 0, "R1 after reset");

    // R2: edges without sampling are unseen
    step(8'h28, 0, 0, 0, 0, "R2 unsampled");
    step(8'h28, 0, 0, 0, 0, "R2 unsampled hold");
    step(8'h28, 1, 0, 0, 0, "R2 sampled");
    step(8'h28, 1, 0, 0, 0, "R3 lowest index offered");
    // R6: accept 3, then run to completion blocks new offers
    step(8'h28, 1, 1, 0, 0, "R4 accept");
    step(8'h00, 1, 0, 0, 0, "R6 blocked");
    step(8'h02, 1, 0, 0, 0, "R6 new arrival blocked");
    step(8'h02, 1, 0, 0, 0, "R6 still blocked");
    step(8'h02, 1, 0, 1, 0, "R5 retire");
    step(8'h02, 1, 0, 0, 0, "R8 new arrival first");
    step(8'h02, 1, 1, 0, 0, "R8 accept 1");
    step(8'h02, 1, 0, 1, 0, "R5 retire 1");
    step(8'h02, 1, 1, 0, 0, "R8 drain 5");
    step(8'h02, 1, 0, 1, 0, "R5 retire 5");
    step(8'h00, 1, 0, 0, 0, "R9 idle id zero");
    step(8'h00, 1, 1, 0, 0, "R4 ack ignored");
    step(8'h00, 1, 0, 1, 0, "R5 eos ignored");
    step(8'h00, 1, 0, 0, 0, "R5 still empty");

    // nested mode
    step(8'h10, 1, 0, 0, 1, "R2 pend 4");
    step(8'h10, 1, 1, 0, 1, "R4 accept 4");
    step(8'h50, 1, 0, 0, 1, "R7 lower rank waits");
    step(8'h50, 1, 0, 0, 1, "R7 6 not offered");
    step(8'h54, 1, 0, 0, 1, "R7 2 arrives");
    step(8'h54, 1, 0, 0, 1, "R7 2 offered");
    step(8'h54, 1, 1, 0, 1, "R7 accept nested");
    step(8'h54, 1, 0, 0, 1, "R7 two open");
    step(8'h54, 1, 0, 1, 1, "R5 retire inner");
    step(8'h54, 1, 0, 1, 1, "R5 retire outer");
    step(8'h54, 1, 0, 0, 1, "R8 6 served last");
    step(8'h54, 1, 1, 0, 1, "R8 accept 6");
    step(8'h54, 1, 0, 1, 1, "R5 retire 6");

    // R10: rising edge during acknowledge of same source
    step(8'h01, 1, 0, 0, 1, "R10 pend 0");
    step(8'h00, 1, 0, 0, 1, "R10 drop level");
    step(8'h01, 1, 1, 0, 1, "R10 rise with ack");
    step(8'h01, 1, 0, 1, 1, "R10 retire");
    step(8'h00, 1, 0, 0, 1, "R10 still pending");
    step(8'h00, 1, 1, 0, 1, "R10 accept again");
    step(8'h00, 1, 0, 1, 1, "R10 retire again");

    // mixed traffic
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r  = lf[7:0] & lf[15:8];
      step(r, lf[3] | lf[9], lf[5] & lf[1], lf[6] & lf[11], (k / 150) % 2 == 1,
           "R8 mixed");
    end
    for (int k = 0; k < 40; k++) step('0, 1, k % 2 == 0, k % 2 == 1, 0, "R8 drain");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule